// File: doc/BRIEF.md
# MDIO Management Master

This block is the station-side master of a two-wire serial management bus. It serves a host that needs to read or write 16-bit registers in an attached PHY. The host presents a command for one cycle: a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The master then builds a complete management frame in 64 MDC cycles and sends it out. The frame is 32 preamble ones, the start pattern, the opcode, both addresses, the turnaround and the data field.

The master derives MDC from the system clock with a programmable divider. MDC runs only while a frame is in progress. The master drives MDIO through an output value and an output enable. It changes MDIO when MDC falls and samples the line when MDC rises. On a read it releases the line for the turnaround and data bits. It checks that the PHY pulls the second turnaround bit low, and shifts in the returned data. Completion is signalled by a one-cycle done pulse, which comes with the read data and a turnaround error flag.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 bit times in which MDIO is driven (`mdio_oe`=1) to 1, one per MDC cycle; the frame is 64 MDC cycles long in total.
- R2: Bit times 32..45 are driven as start `0,1`, opcode (`1,0` for read with `cmd_read`=1, `0,1` for write), then PHY address and register address, each most significant bit first.
- R3: On a write, bit times 46 and 47 are driven `1,0`, and bit times 48..63 carry `cmd_wdata` most significant bit first; `mdio_oe` stays 1 for the whole frame.
- R4: While busy, `mdio_o` and `mdio_oe` change only in the cycle in which MDC falls.
- R5: On a read, `mdio_oe` is 0 for bit times 46..63. `rd_data` holds the 16 values of `mdio_i` sampled at the MDC rises of bit times 48..63, the first one in bit 15.
- R6: On a read, `ta_err` is 1 at completion if `mdio_i` was 1 at the MDC rise of bit time 47, and 0 otherwise; on a write it is 0.
- R7: MDC is low whenever the master is idle. During a frame, MDC starts low and each phase lasts `div_half`+1 system clocks, so the rise-to-rise period is 2*(`div_half`+1) clocks; `div_half` is captured when the command is accepted.
- R8: After the MDC fall that ends bit time 63, `done` is high for exactly one cycle, `busy` is 0 and `mdio_oe` is 0, so the line idles high through its pull-up.
- R9: A command is accepted only when `cmd_valid`=1 and `busy`=0; a command presented while busy neither alters the running frame nor starts another one.
- R10: After reset, `busy`, `done`, `mdc`, `mdio_oe` and `ta_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| div_half | input | DIV_W | MDC half period in system clocks, minus one |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, valid with done |
| ta_err | output | 1 | PHY did not drive 0 in second turnaround bit |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
The bench builds the block with `DIV_W`=4. With that width every divider setting from 0 to 15 is in reach, and the bench uses the fastest setting 0 (MDC at half the system clock), 1, 3 and the slowest setting 15. At each of these settings it measures the MDC period and checks each of the 64 bits. A bench PHY model answers reads. It can hold the second turnaround bit high, which brings out the error flag. Another case injects a command partway through a frame, which shows that the running frame is kept and that no second frame follows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 2 + 2 + PHY_AW + REG_AW;
  localparam int TA_BITS    = 2;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = PRE_BITS + HDR_BITS;
  localparam int DATA_FIRST = TA_FIRST + TA_BITS;

  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(TA_FIRST + 1);
  localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(DATA_FIRST);

  typedef struct packed {
    logic              rd;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  typedef struct packed {
    logic oe;
    logic val;
  } mdio_pin_t;

  // Pin state for one bit time of the frame, selected by bit index.
  function automatic mdio_pin_t frame_bit(input logic [IDX_W-1:0] idx,
                                          input mdio_cmd_t c);
    mdio_pin_t         r;
    int                i;
    logic [PHY_AW-1:0] p;
    logic [REG_AW-1:0] g;
    logic [DATA_W-1:0] d;
    i     = int'(idx);
    r.oe  = 1'b1;
    r.val = 1'b1;
    p     = c.phy << (i - PRE_BITS - 4);
    g     = c.regad << (i - PRE_BITS - 4 - PHY_AW);
    d     = c.wdata << (i - DATA_FIRST);
    if (i < PRE_BITS)                    r.val = 1'b1;
    else if (i == PRE_BITS)              r.val = 1'b0;
    else if (i == PRE_BITS + 1)          r.val = 1'b1;
    else if (i == PRE_BITS + 2)          r.val = c.rd;
    else if (i == PRE_BITS + 3)          r.val = !c.rd;
    else if (i < PRE_BITS + 4 + PHY_AW)  r.val = p[PHY_AW-1];
    else if (i < TA_FIRST)               r.val = g[REG_AW-1];
    else if (c.rd)                       r.oe  = 1'b0;
    else if (i == TA_FIRST)              r.val = 1'b1;
    else if (i == TA_FIRST + 1)          r.val = 1'b0;
    else                                 r.val = d[DATA_W-1];
    return r;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt;
  logic             term;

  assign term     = busy && (cnt == half_q);
  assign rise_evt = term && !mdc;
  assign fall_evt = term && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= div_half;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else if (busy) begin
      if (term) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end

  assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_mdc_phase_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdc != $past(mdc))) |-> ($past(cnt) == $past(half_q)));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  mdio_cmd_t        cmd_in,
  input  logic             fall_evt,
  output logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] idx,
  output mdio_cmd_t        cmd_q
);
  logic last_bit;

  assign start    = cmd_valid && !busy;
  assign last_bit = (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      cmd_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        cmd_q <= cmd_in;
      end else if (fall_evt) begin
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(cmd_q));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rise_evt,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic              mdio_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              ta_err
);
  logic sample_ta;
  logic sample_data;

  assign sample_ta   = rise_evt && rd && (idx == IDX_TA2);
  assign sample_data = rise_evt && rd && (idx >= IDX_DATA0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      ta_err  <= 1'b0;
    end else if (start) begin
      rd_data <= '0;
      ta_err  <= 1'b0;
    end else begin
      if (sample_ta)   ta_err  <= mdio_i;
      if (sample_data) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
    end
  end

  assert_ta_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ta |=> (ta_err == $past(mdio_i)));
  assert_data_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_data |=> (rd_data[0] == $past(mdio_i)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_wdata,
  input  logic [DIV_W-1:0] div_half,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             ta_err,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic             start;
  logic             rise_evt;
  logic             fall_evt;
  logic [IDX_W-1:0] idx;
  mdio_cmd_t        cmd_in;
  mdio_cmd_t        cmd_q;
  mdio_pin_t        pin;

  assign cmd_in = '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};

  mdio_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_in   (cmd_in),
    .fall_evt (fall_evt),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .idx      (idx),
    .cmd_q    (cmd_q)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .div_half(div_half),
    .mdc     (mdc),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  mdio_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rise_evt(rise_evt),
    .rd      (cmd_q.rd),
    .idx     (idx),
    .mdio_i  (mdio_i),
    .rd_data (rd_data),
    .ta_err  (ta_err)
  );

  assign pin     = frame_bit(idx, cmd_q);
  assign mdio_oe = busy && pin.oe;
  assign mdio_o  = busy ? pin.val : 1'b1;

  assert_drive_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q.rd && (idx >= IDX_TA1)) |-> !mdio_oe);
  assert_write_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_q.rd) |-> mdio_oe);
  assert_write_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_q.rd) |-> !ta_err);
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_read = 1'b0;
  logic [4:0]       cmd_phy = '0;
  logic [4:0]       cmd_reg = '0;
  logic [15:0]      cmd_wdata = '0;
  logic [DIV_W-1:0] div_half = '0;
  logic             busy, done, ta_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0]      rd_data;
  logic             phy_en = 1'b0;
  logic             phy_val = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Line model: master drive, else PHY drive, else pull-up.
  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_master #(.DIV_W(DIV_W)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .div_half(div_half), .busy(busy), .done(done), .rd_data(rd_data),
    .ta_err(ta_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one frame, acting as the PHY, and checks everything it observes.
  task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input int div,
                           input logic [15:0] phy_data, input bit bad_ta,
                           input bit inject);
    logic [63:0] exp_v, got_v, got_oe;
    int n = 0, cyc = 0, last_rise = -1, period_bad = 0, done_cnt = 0;
    bit prev = 0, injected = 0, seen_done = 0, seen_busy_after = 0, seen_oe_after = 0;
    logic [15:0] got_rd = '0;
    bit got_err = 0;
    exp_v  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
              (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
    got_v  = '0;
    got_oe = '0;
    @(negedge clk);
    cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    div_half = DIV_W'(div); cmd_valid = 1'b1;
    while (!seen_done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      cmd_valid = 1'b0;
      if (mdc && !prev) begin
        if (n < 64) begin
          got_v[63-n]  = mdio_o;
          got_oe[63-n] = mdio_oe;
        end
        if (last_rise >= 0 && (cyc - last_rise) != 2 * (div + 1)) period_bad++;
        last_rise = cyc;
        n++;
        if (inject && n == 10 && !injected) begin
          injected = 1;
          cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
          div_half = '0; cmd_valid = 1'b1;
        end
      end
      if (!mdc && prev && rd && n >= 47 && n < 64) begin
        phy_en  = 1'b1;
        phy_val = (n == 47) ? bad_ta : phy_data[15-(n-48)];
      end
      if (done) begin
        done_cnt++;
        seen_done = 1;
        got_rd  = rd_data;
        got_err = ta_err;
        seen_busy_after = busy;
        seen_oe_after   = mdio_oe;
      end
      prev = mdc;
    end
    if (!seen_done) begin
      check(0, "R8", "done never seen", 0, 1);
    end
    @(negedge clk);
    if (done) done_cnt++;
    phy_en = 1'b0;
    check(n == 64, "R1", "MDC rising edges per frame", n, 64);
    check(got_v[63:32] == exp_v[63:32] && got_oe[63:32] == 32'hFFFF_FFFF,
          "R1", "preamble bits", got_v[63:32], exp_v[63:32]);
    check(got_v[31:18] == exp_v[31:18] && got_oe[31:18] == 14'h3FFF,
          "R2", "start/opcode/address bits", got_v[31:18], exp_v[31:18]);
    if (rd) begin
      check(got_oe[17:0] == '0, "R5", "line released in turnaround and data",
            got_oe[17:0], 0);
      check(got_rd == phy_data, "R5", "read data", got_rd, phy_data);
      check(got_err == bad_ta, "R6", "turnaround error flag", got_err, bad_ta);
    end else begin
      check(got_v[17:0] == exp_v[17:0] && got_oe[17:0] == 18'h3FFFF,
            "R3", "write turnaround and data", got_v[17:0], exp_v[17:0]);
      check(got_err == 0, "R6", "no error on write", got_err, 0);
    end
    check(period_bad == 0, "R7", "MDC period mismatches", period_bad, 0);
    check(done_cnt == 1, "R8", "done pulse length", done_cnt, 1);
    check(!seen_busy_after && !seen_oe_after && mdio_i,
          "R8", "idle after frame (busy,oe,line)",
          {seen_busy_after, seen_oe_after, mdio_i}, 3'b001);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe && !ta_err, "R10",
          "reset state (busy,done,mdc,oe,err)",
          {busy, done, mdc, mdio_oe, ta_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mdc && !busy, "R7", "MDC low while idle", {busy, mdc}, 0);
  endtask

  task automatic t_write_basic();
    run_frame(0, 5'b10011, 5'b00101, 16'hA5C3, 1, 16'h0, 0, 0);
  endtask

  task automatic t_write_slow();
    run_frame(0, 5'b01100, 5'b11110, 16'h1234, 15, 16'h0, 0, 0);
  endtask

  task automatic t_read_ok();
    run_frame(1, 5'b00001, 5'b10000, 16'hFFFF, 0, 16'hB00F, 0, 0);
  endtask

  task automatic t_read_bad_ta();
    run_frame(1, 5'b11111, 5'b00011, 16'h0, 3, 16'h6A59, 1, 0);
  endtask

  task automatic t_busy_ignore();
    int mdc_seen = 0;
    int busy_seen = 0;
    run_frame(0, 5'b01010, 5'b10101, 16'h0F0E, 1, 16'h0, 0, 1);
    repeat (30) begin
      @(negedge clk);
      if (mdc) mdc_seen++;
      if (busy) busy_seen++;
    end
    check(mdc_seen == 0 && busy_seen == 0, "R9", "no frame from command given while busy",
          mdc_seen + busy_seen, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_basic();
    t_read_ok();
    t_read_bad_ta();
    t_write_slow();
    t_busy_ignore();
    t_read_ok();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule